// File: doc/BRIEF.md
# Page Map Entry Update Unit

This block keeps a table of virtual-to-real page map entries in a small synchronous RAM, indexed by the virtual page number. A client issues one command at a time over a valid/ready handshake. The three commands do the following:

- **Set-map** writes a fresh real page and flag set into an entry.
- **Set-flags** replaces the flag field of an existing entry and returns the entry's previous contents.
- **Get-flags** returns the flag field and real page of an entry without changing it.

Every stored entry is a 16-bit word. The 3-bit flag field sits in bits 11..9 and is ordered write-protected, dirty, referenced. The 13-bit real page is split around the flag field: its low nibble is in bits 15..12 and its upper nine bits are in bits 8..0.

Set-flags is a read-modify-write with two special rules:

- An entry that is vacant (flag code 110) can never be revived by a flag update.
- Writing the vacant code clears the real page field.

Two combinational access-permission outputs are decoded from the returned flags:

- `read_ok` follows the referenced bit.
- `write_ok` is set when the write-protect bit is clear and the dirty bit is set.

The controller is a three-state machine:

- **IDLE** accepts commands and is the only state with `cmd_ready` high.
- **FETCH** captures the RAM read word.
- **COMMIT** presents the response and, for set-flags only, writes the merged entry.

The transitions are:

- IDLE→FETCH on accepting set-flags or get-flags.
- IDLE→IDLE on accepting set-map (written in the same cycle) or no-op.
- FETCH→COMMIT always.
- COMMIT→IDLE always.

Top module: `pmap_update_unit`

## Requirements
- R1: After reset `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: Set-map (`cmd_op` = 00) stores the flags and real page so that a later get-flags of the same virtual page returns exactly those flags and that 13-bit real page (zero-extended to 16 bits). In the entry, real page bits 3..0 go to entry bits 15..12, flags to bits 11..9, and real page bits 12..4 to bits 8..0.
- R3: Argument bits outside the used fields are ignored. These are `cmd_vpage` above the index width, `cmd_rpage` above bit 12, and `cmd_flags` above bit 2.
- R4: Set-flags (`cmd_op` = 01) returns the old flags and old real page as separate result fields. When neither the old nor the new flags are vacant (110), it stores the new flags with the old real page kept.
- R5: Set-flags with new flags 110 on a non-vacant entry stores flags 110 and real page 0.
- R6: Set-flags on an entry whose old flags are 110 leaves the entry unchanged, whatever flags are requested.
- R7: Get-flags (`cmd_op` = 10) returns the old flags and real page and never writes the RAM.
- R8: A set-flags or get-flags accepted at clock edge k drops `cmd_ready` after edge k. It asserts `rsp_valid` for exactly the one cycle after edge k+1, and restores `cmd_ready` after edge k+2. No command is accepted in between.
- R9: `read_ok` equals bit 0 of `rsp_flags`. `write_ok` is 1 exactly when `rsp_flags[2:1]` is 01, so it is 1 for code 011 and for reserved code 010.
- R10: Command code 11 is a no-op: it is accepted, produces no response and changes no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with `cmd_valid` |
| cmd_op | input | 2 | 00 set-map, 01 set-flags, 10 get-flags, 11 no-op |
| cmd_vpage | input | 32 | Virtual page; low `VPN_W` bits index the table |
| cmd_rpage | input | 32 | Real page for set-map; low 13 bits used |
| cmd_flags | input | 16 | Flags argument; low 3 bits used (w,d,r) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_flags | output | 3 | Old flags of the addressed entry |
| rsp_rpage | output | 16 | Old real page, zero-extended |
| read_ok | output | 1 | Read permission decoded from `rsp_flags` |
| write_ok | output | 1 | Write permission decoded from `rsp_flags` |

## Verification
The table is first filled with set-map commands that span all eight flag codes. The real pages are chosen so that bits on both sides of the flag field are set, so a swapped nibble or shifted field shows up on read-back. Set-flags is then applied to three kinds of entry: an ordinary entry with an ordinary target, an ordinary entry with the vacant target, and a vacant entry with an ordinary target. These separate the page-keeping merge, the clearing rule and the sticky-vacant rule. Repeated get-flags, a no-op, and a command held waiting while the unit is busy confirm that nothing is written or accepted outside the proper slot.

// File: rtl/pmap_pkg.sv
package pmap_pkg;

    localparam int FLAG_W    = 3;
    localparam int RPN_W     = 13;
    localparam int ENTRY_W   = 16;
    localparam int RPN_LO_W  = 4;
    localparam int RPN_HI_W  = RPN_W - RPN_LO_W;
    localparam int FLAG_LSB  = RPN_HI_W;
    localparam int RPN_LO_LSB = FLAG_LSB + FLAG_W;

    typedef enum logic [1:0] {
        OP_SET_MAP   = 2'b00,
        OP_SET_FLAGS = 2'b01,
        OP_GET_FLAGS = 2'b10,
        OP_NOP       = 2'b11
    } pmap_op_e;

    localparam logic [FLAG_W-1:0] FLAGS_VACANT = 3'b110;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [RPN_W-1:0]  rpn;
    } pmap_fields_t;

    function automatic logic [ENTRY_W-1:0] pack_entry(input pmap_fields_t f);
        logic [ENTRY_W-1:0] e;
        e = '0;
        e[ENTRY_W-1:RPN_LO_LSB]     = f.rpn[RPN_LO_W-1:0];
        e[RPN_LO_LSB-1:FLAG_LSB]    = f.flags;
        e[RPN_HI_W-1:0]             = f.rpn[RPN_W-1:RPN_LO_W];
        return e;
    endfunction

    function automatic pmap_fields_t unpack_entry(input logic [ENTRY_W-1:0] e);
        pmap_fields_t f;
        f.flags = e[RPN_LO_LSB-1:FLAG_LSB];
        f.rpn   = {e[RPN_HI_W-1:0], e[ENTRY_W-1:RPN_LO_LSB]};
        return f;
    endfunction

endpackage

// File: rtl/pmap_ram.sv
module pmap_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end
endmodule

// File: rtl/pmap_merge.sv
module pmap_merge
    import pmap_pkg::*;
(
    input  logic [ENTRY_W-1:0] old_entry,
    input  logic [FLAG_W-1:0]  new_flags,
    output logic [ENTRY_W-1:0] new_entry
);
    pmap_fields_t old_f;
    pmap_fields_t res_f;

    always_comb begin
        old_f = unpack_entry(old_entry);
        res_f = old_f;
        if (old_f.flags == FLAGS_VACANT) begin
            res_f = old_f;
        end else if (new_flags == FLAGS_VACANT) begin
            res_f.flags = FLAGS_VACANT;
            res_f.rpn   = '0;
        end else begin
            res_f.flags = new_flags;
            res_f.rpn   = old_f.rpn;
        end
        new_entry = pack_entry(res_f);
    end
endmodule

// File: rtl/pmap_access_decode.sv
module pmap_access_decode
    import pmap_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    output logic              read_ok,
    output logic              write_ok
);
    // flags = {write_protected, dirty, referenced}
    always_comb begin
        read_ok  = flags[0];
        write_ok = (flags[2:1] == 2'b01);
    end
endmodule

// File: rtl/pmap_ctrl.sv
module pmap_ctrl
    import pmap_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  pmap_op_e           cmd_op,
    input  logic [ADDR_W-1:0]  cmd_index,
    input  logic [RPN_W-1:0]   cmd_rpn,
    input  logic [FLAG_W-1:0]  cmd_flg,
    output logic [ADDR_W-1:0]  ram_addr,
    output logic               ram_we,
    output logic [ENTRY_W-1:0] ram_wdata,
    input  logic [ENTRY_W-1:0] ram_rdata,
    output logic [ENTRY_W-1:0] old_entry,
    output logic [FLAG_W-1:0]  req_flags,
    input  logic [ENTRY_W-1:0] merged_entry,
    output pmap_op_e           cur_op,
    output logic               rsp_valid,
    output logic [FLAG_W-1:0]  rsp_flags,
    output logic [RPN_W-1:0]   rsp_rpn
);
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_FETCH  = 2'b01,
        ST_COMMIT = 2'b10
    } state_e;

    state_e state_q, state_d;

    pmap_op_e          op_q;
    logic [ADDR_W-1:0] idx_q;
    logic [FLAG_W-1:0] flg_q;
    logic [ENTRY_W-1:0] old_q;
    pmap_fields_t      old_f;

    logic accept;
    logic is_lookup;

    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign is_lookup = (cmd_op == OP_SET_FLAGS) || (cmd_op == OP_GET_FLAGS);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && is_lookup) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH:  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // command and read-word capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= OP_NOP;
            idx_q <= '0;
            flg_q <= '0;
            old_q <= '0;
        end else begin
            if (accept) begin
                op_q  <= cmd_op;
                idx_q <= cmd_index;
                flg_q <= cmd_flg;
            end
            if (state_q == ST_FETCH) begin
                old_q <= ram_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        pmap_fields_t wr_f;
        wr_f.flags = cmd_flg;
        wr_f.rpn   = cmd_rpn;
        cmd_ready  = 1'b0;
        ram_addr   = idx_q;
        ram_we     = 1'b0;
        ram_wdata  = '0;
        rsp_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                ram_addr  = cmd_index;
                if (cmd_valid && (cmd_op == OP_SET_MAP)) begin
                    ram_we    = 1'b1;
                    ram_wdata = pack_entry(wr_f);
                end
            end
            ST_FETCH: begin
                ram_addr = idx_q;
            end
            ST_COMMIT: begin
                rsp_valid = 1'b1;
                if (op_q == OP_SET_FLAGS) begin
                    ram_we    = 1'b1;
                    ram_wdata = merged_entry;
                end
            end
            default: begin
                cmd_ready = 1'b0;
            end
        endcase
    end

    assign old_f     = unpack_entry(old_q);
    assign old_entry = old_q;
    assign req_flags = flg_q;
    assign cur_op    = op_q;
    assign rsp_flags = old_f.flags;
    assign rsp_rpn   = old_f.rpn;
endmodule

// File: rtl/pmap_update_unit.sv
module pmap_update_unit
    import pmap_pkg::*;
#(
    parameter int VPN_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [1:0]  cmd_op,
    input  logic [31:0] cmd_vpage,
    input  logic [31:0] cmd_rpage,
    input  logic [15:0] cmd_flags,
    output logic        rsp_valid,
    output logic [2:0]  rsp_flags,
    output logic [15:0] rsp_rpage,
    output logic        read_ok,
    output logic        write_ok
);
    localparam int RPAGE_PAD = 16 - RPN_W;

    logic [VPN_W-1:0]   ram_addr;
    logic               ram_we;
    logic [ENTRY_W-1:0] ram_wdata;
    logic [ENTRY_W-1:0] ram_rdata;
    logic [ENTRY_W-1:0] old_entry;
    logic [ENTRY_W-1:0] merged_entry;
    logic [FLAG_W-1:0]  req_flags;
    logic [RPN_W-1:0]   rsp_rpn;
    pmap_op_e           cur_op;
    pmap_op_e           op_in;

    logic unused_arg_bits;
    assign unused_arg_bits = ^{cmd_vpage[31:VPN_W], cmd_rpage[31:RPN_W],
                               cmd_flags[15:FLAG_W]};

    assign op_in = pmap_op_e'(cmd_op);

    pmap_ctrl #(.ADDR_W(VPN_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_op       (op_in),
        .cmd_index    (cmd_vpage[VPN_W-1:0]),
        .cmd_rpn      (cmd_rpage[RPN_W-1:0]),
        .cmd_flg      (cmd_flags[FLAG_W-1:0]),
        .ram_addr     (ram_addr),
        .ram_we       (ram_we),
        .ram_wdata    (ram_wdata),
        .ram_rdata    (ram_rdata),
        .old_entry    (old_entry),
        .req_flags    (req_flags),
        .merged_entry (merged_entry),
        .cur_op       (cur_op),
        .rsp_valid    (rsp_valid),
        .rsp_flags    (rsp_flags),
        .rsp_rpn      (rsp_rpn)
    );

    pmap_ram #(.ADDR_W(VPN_W), .DATA_W(ENTRY_W)) u_ram (
        .clk   (clk),
        .addr  (ram_addr),
        .we    (ram_we),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    pmap_merge u_merge (
        .old_entry (old_entry),
        .new_flags (req_flags),
        .new_entry (merged_entry)
    );

    pmap_access_decode u_decode (
        .flags    (rsp_flags),
        .read_ok  (read_ok),
        .write_ok (write_ok)
    );

    assign rsp_rpage = {{RPAGE_PAD{1'b0}}, rsp_rpn};
endmodule

// File: rtl/pmap_update_sva.sv
module pmap_update_sva
    import pmap_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_valid,
    input logic         cmd_ready,
    input logic [1:0]   cmd_op,
    input logic         rsp_valid,
    input logic [2:0]   rsp_flags,
    input logic [15:0]  rsp_rpage,
    input logic         ram_we,
    input logic [15:0]  ram_wdata,
    input pmap_op_e     cur_op
);
    logic take_lookup;
    logic take_nop;
    assign take_lookup = cmd_valid && cmd_ready &&
                         (cmd_op == OP_SET_FLAGS || cmd_op == OP_GET_FLAGS);
    assign take_nop    = cmd_valid && cmd_ready && (cmd_op == OP_NOP);

    AST_RSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready); // R8
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R8
    AST_READY_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> cmd_ready); // R8
    AST_LOOKUP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        take_lookup |=> (!cmd_ready && !rsp_valid)); // R8
    AST_GET_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cur_op == OP_GET_FLAGS) |-> !ram_we); // R7
    AST_VACANT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && ram_we && rsp_flags == FLAGS_VACANT)
            |-> (ram_wdata[11:9] == FLAGS_VACANT)); // R6
    AST_KEEP_RPAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && ram_we && rsp_flags != FLAGS_VACANT && ram_wdata[11:9] != FLAGS_VACANT)
            |-> ({ram_wdata[8:0], ram_wdata[15:12]} == rsp_rpage[12:0])); // R4
    AST_VACANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && ram_we && rsp_flags != FLAGS_VACANT && ram_wdata[11:9] == FLAGS_VACANT)
            |-> (ram_wdata[8:0] == 9'd0 && ram_wdata[15:12] == 4'd0)); // R5
    AST_NOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        take_nop |-> !ram_we); // R10
    AST_NOP_STAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        take_nop |=> (cmd_ready && !rsp_valid)); // R10
endmodule

bind pmap_update_unit pmap_update_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .rsp_valid (rsp_valid),
    .rsp_flags (rsp_flags),
    .rsp_rpage (rsp_rpage),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .cur_op    (cur_op)
);

// File: tb/pmap_update_unit_tb.sv
module pmap_update_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'b11;
    logic [31:0] cmd_vpage = '0;
    logic [31:0] cmd_rpage = '0;
    logic [15:0] cmd_flags = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_flags;
    logic [15:0] rsp_rpage;
    logic        read_ok;
    logic        write_ok;

    always #10 clk = ~clk;

    pmap_update_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_vpage (cmd_vpage),
        .cmd_rpage (cmd_rpage),
        .cmd_flags (cmd_flags),
        .rsp_valid (rsp_valid),
        .rsp_flags (rsp_flags),
        .rsp_rpage (rsp_rpage),
        .read_ok   (read_ok),
        .write_ok  (write_ok)
    );

    typedef struct {
        logic [2:0]  flg;
        logic [15:0] rp;
        logic        rok;
        logic        wok;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [2:0]  m_flg [256];
    logic [15:0] m_rp  [256];

    localparam logic [1:0] C_MAP = 2'b00, C_SETF = 2'b01, C_GETF = 2'b10, C_NOP = 2'b11;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // driver: waits for acceptance, updates model, pushes expectations
    task automatic send(input logic [1:0] op, input logic [31:0] vp,
                        input logic [31:0] rp, input logic [15:0] fl, input string tag);
        int idx;
        exp_t e;
        idx = int'(vp[7:0]);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_vpage = vp;
        cmd_rpage = rp;
        cmd_flags = fl;
        while (!cmd_ready) @(negedge clk);
        case (op)
            C_MAP: begin
                m_flg[idx] = fl[2:0];
                m_rp[idx]  = {3'b000, rp[12:0]};
            end
            C_SETF, C_GETF: begin
                e.flg = m_flg[idx];
                e.rp  = m_rp[idx];
                e.rok = m_flg[idx][0];
                e.wok = (m_flg[idx][2:1] == 2'b01);
                e.tag = tag;
                exp_q.push_back(e);
                if (op == C_SETF && m_flg[idx] != 3'b110) begin
                    if (fl[2:0] == 3'b110) begin
                        m_flg[idx] = 3'b110;
                        m_rp[idx]  = 16'h0000;
                    end else begin
                        m_flg[idx] = fl[2:0];
                    end
                end
            end
            default: ;
        endcase
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = C_NOP;
    endtask

    // monitor: compares every response against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected response flags", {29'd0, rsp_flags}, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rsp_flags == e.flg, e.tag, "rsp_flags", {29'd0, rsp_flags}, {29'd0, e.flg});
                    check(rsp_rpage == e.rp, e.tag, "rsp_rpage", {16'd0, rsp_rpage}, {16'd0, e.rp});
                    check(read_ok == e.rok, "R9", "read_ok", {31'd0, read_ok}, {31'd0, e.rok});
                    check(write_ok == e.wok, "R9", "write_ok", {31'd0, write_ok}, {31'd0, e.wok});
                end
            end
        end
    end

    task automatic drain();
        for (int i = 0; i < 10; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 20000);
        check(1'b0, "R8", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cmd_ready == 1'b1, "R1", "cmd_ready after reset", {31'd0, cmd_ready}, 32'd1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);

        // R2 fill across all flag codes
        send(C_MAP, 32'd1, 32'h0000_1ABC, 16'h0000, "R2");
        send(C_MAP, 32'd2, 32'h0000_0001, 16'h0003, "R2");
        send(C_MAP, 32'd3, 32'h0000_1000, 16'h0005, "R2");
        send(C_MAP, 32'd4, 32'h0000_0F0F, 16'h0006, "R2");
        send(C_MAP, 32'hABCD_0005, 32'hFFFF_E123, 16'hFFF9, "R3");
        send(C_MAP, 32'd6, 32'h0000_0555, 16'h0002, "R2");
        send(C_MAP, 32'd7, 32'h0000_1FFF, 16'h0007, "R2");
        send(C_MAP, 32'd8, 32'h0000_0246, 16'h0004, "R2");

        // R8 timing around a get-flags
        send(C_GETF, 32'd1, 32'd0, 16'd0, "R2");
        check(cmd_ready == 1'b0, "R8", "ready after accept", {31'd0, cmd_ready}, 32'd0);
        check(rsp_valid == 1'b0, "R8", "rsp before slot", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        check(rsp_valid == 1'b1, "R8", "rsp in slot", {31'd0, rsp_valid}, 32'd1);
        check(cmd_ready == 1'b0, "R8", "ready in rsp slot", {31'd0, cmd_ready}, 32'd0);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8", "rsp after slot", {31'd0, rsp_valid}, 32'd0);
        check(cmd_ready == 1'b1, "R8", "ready restored", {31'd0, cmd_ready}, 32'd1);

        for (int v = 2; v <= 8; v++) begin
            send(C_GETF, 32'(v), 32'd0, 16'd0, (v == 5) ? "R3" : "R2");
        end

        // R4 ordinary set-flags keeps the real page (held command waits while busy)
        send(C_SETF, 32'd1, 32'hFFFF_FFFF, 16'h0003, "R4");
        send(C_GETF, 32'd1, 32'd0, 16'd0, "R4");
        send(C_SETF, 32'd8, 32'd0, 16'hFFF9, "R3");
        send(C_GETF, 32'd8, 32'd0, 16'd0, "R3");

        // R5 new vacant clears the page
        send(C_SETF, 32'd2, 32'd0, 16'h0006, "R5");
        send(C_GETF, 32'd2, 32'd0, 16'd0, "R5");

        // R6 old vacant stays vacant
        send(C_SETF, 32'd4, 32'd0, 16'h0001, "R6");
        send(C_GETF, 32'd4, 32'd0, 16'd0, "R6");
        send(C_SETF, 32'd2, 32'd0, 16'h0003, "R6");
        send(C_GETF, 32'd2, 32'd0, 16'd0, "R6");

        // R7 get-flags twice, no change
        send(C_GETF, 32'd7, 32'd0, 16'd0, "R7");
        send(C_GETF, 32'd7, 32'd0, 16'd0, "R7");

        // R10 no-op then read back
        send(C_NOP, 32'd3, 32'h0000_0777, 16'h0003, "R10");
        check(cmd_ready == 1'b1, "R10", "ready after nop", {31'd0, cmd_ready}, 32'd1);
        send(C_GETF, 32'd3, 32'd0, 16'd0, "R10");

        // R2 overwrite then read back
        send(C_MAP, 32'd1, 32'h0000_0ACE, 16'h0001, "R2");
        send(C_GETF, 32'd1, 32'd0, 16'd0, "R2");

        drain();
        check(exp_q.size() == 0, "R8", "responses outstanding", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule